// File: doc/BRIEF.md
# Streaming 4x4 Integer Matrix Multiplier

This block takes two square matrices of signed 32-bit integers, called A and B, each delivered as a stream of elements. It returns their product C = A·B as a third stream. A and B arrive on two separate AXI4-Stream slave ports. The block takes one element from each port in the same cycle, so the two streams advance together. Both operands are kept in internal register banks. Once the last operand pair is stored, the block reads a whole row of A and a whole column of B in the same cycle. From these it forms one dot product per cycle and sends it on an AXI4-Stream master port.

There is no start, busy or done signal. After the final result beat leaves, the block goes back to collecting operands. The next product can then be streamed in straight away. The dimension, the element width and the form of the summation network are parameters. The default is a 4x4 matrix of 32-bit elements, summed by a balanced adder tree.

Top module: `mxm_stream_mul`

## Requirements
- R1: `a_tready` and `b_tready` are always equal. Both are high exactly when the block is collecting operands and both `a_tvalid` and `b_tvalid` are high. They are low while results are being sent.
- R2: The n-th accepted operand pair, counting from 0, is stored as element row n/4, column n%4 of A and of B. Operands therefore arrive in row-major order.
- R3: `m_tvalid` stays low until all 16 operand pairs have been accepted. It goes high in the cycle that follows the clock edge at which the 16th pair is accepted.
- R4: Each result is C[i][j], the sum over k = 0..3 of A[i][k]·B[k][j]. All products and sums are taken modulo 2^32 in two's complement.
- R5: The 16 results are sent in row-major order, with the row index outer and the column index inner.
- R6: `m_tlast` is high on the 16th result beat only. It is low on the first 15 beats.
- R7: `m_tkeep` is all ones on every result beat.
- R8: While `m_tvalid` is high and `m_tready` is low, `m_tdata`, `m_tlast` and the position within the result sequence do not change.
- R9: After the 16th result beat is accepted, the block returns to collecting operands with no other stimulus. It accepts a new operand pair from the next cycle onward.
- R10: From the first result to the 16th, `m_tvalid` stays high in every cycle. A new result is offered in each cycle that follows an accepted beat.
- R11: `rst_n` is an active-low synchronous reset. It clears all progress, drives `m_tvalid` low and returns the block to collecting operands from the first pair, whatever phase the block was in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_tdata | input | 32 | Element of matrix A |
| a_tvalid | input | 1 | A element valid |
| a_tready | output | 1 | A element accepted (paired with B) |
| b_tdata | input | 32 | Element of matrix B |
| b_tvalid | input | 1 | B element valid |
| b_tready | output | 1 | B element accepted (paired with A) |
| m_tdata | output | 32 | Result element of C |
| m_tvalid | output | 1 | Result valid |
| m_tready | input | 1 | Downstream ready for the result |
| m_tkeep | output | 4 | Byte enables, all ones |
| m_tlast | output | 1 | High on the final result beat |

## Verification
If the load counter skips or stalls, every result is computed from the wrong operands. It also moves the cycle in which `m_tvalid` first rises, so the first compared beat exposes the fault. If the row or column selector is wrong, the affected beat carries a wrong value or comes in the wrong order. A stall that lets the selector advance makes the held beat change. If the phase bit is stuck or returns early, the block either accepts operands while it is sending results or produces fewer than 16 beats. Such faults show within one packet as a ready mismatch, a mistimed TLAST or a missing result. Reset faults show in the next packet, because operands left over from an aborted load would shift every later result.

// File: rtl/mxm_pkg.sv
package mxm_pkg;

   // Two-phase operation: collect operand pairs, then stream results
   typedef enum logic {
      PH_LOAD = 1'b0,
      PH_EMIT = 1'b1
   } mxm_phase_e;

endpackage

// File: rtl/mxm_operand_bank.sv
// Register bank holding one square operand matrix, row-major, every cell
// visible in parallel so that a full row or column can be read in one cycle.
module mxm_operand_bank #(
   parameter int DIM = 4,
   parameter int DW = 32,
   localparam int CELLS = DIM * DIM,
   localparam int IDXW = $clog2(CELLS)
) (
   input  logic                        clk,
   input  logic                        wr_en,
   input  logic [IDXW-1:0]             wr_idx,
   input  logic [DW-1:0]               wr_data,
   output logic [CELLS-1:0][DW-1:0]    cells
);

   for (genvar c = 0; c < CELLS; c++) begin : g_cell
      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == IDXW'(c))) begin
            cells[c] <= wr_data;
         end
      end
   end

endmodule

// File: rtl/mxm_dot_unit.sv
// Combinational dot product of one row and one column, modulo 2^DW.
// ADD_TREE selects a balanced adder tree (shallow) or a linear chain (compact).
module mxm_dot_unit #(
   parameter int DIM = 4,
   parameter int DW = 32,
   parameter bit ADD_TREE = 1'b1
) (
   input  logic [DIM-1:0][DW-1:0] row_v,
   input  logic [DIM-1:0][DW-1:0] col_v,
   output logic [DW-1:0]          dot
);

   logic [DIM-1:0][DW-1:0] prod;

   for (genvar k = 0; k < DIM; k++) begin : g_mul
      assign prod[k] = row_v[k] * col_v[k];
   end

   if (ADD_TREE) begin : g_tree
      // Heap layout: leaves at DIM-1 .. 2*DIM-2, root at 0
      logic [2*DIM-2:0][DW-1:0] node;
      for (genvar k = 0; k < DIM; k++) begin : g_leaf
         assign node[DIM-1+k] = prod[k];
      end
      for (genvar n = 0; n < DIM - 1; n++) begin : g_add
         assign node[n] = node[2*n+1] + node[2*n+2];
      end
      assign dot = node[0];
   end else begin : g_chain
      logic [DIM:0][DW-1:0] part;
      assign part[0] = '0;
      for (genvar k = 0; k < DIM; k++) begin : g_acc
         assign part[k+1] = part[k] + prod[k];
      end
      assign dot = part[DIM];
   end

endmodule

// File: rtl/mxm_sequencer.sv
// Phase control: counts operand pairs while loading, then walks the
// result grid row by row while emitting.
module mxm_sequencer
   import mxm_pkg::*;
#(
   parameter int DIM = 4,
   localparam int CELLS = DIM * DIM,
   localparam int IDXW = $clog2(CELLS),
   localparam int RCW = $clog2(DIM)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            a_valid,
   input  logic            b_valid,
   input  logic            o_ready,
   output logic            in_take,
   output logic            o_valid,
   output logic            o_last,
   output logic [IDXW-1:0] ld_idx,
   output logic [RCW-1:0]  row_sel,
   output logic [RCW-1:0]  col_sel
);

   mxm_phase_e      phase;
   logic [IDXW-1:0] ld_q;
   logic [RCW-1:0]  row_q;
   logic [RCW-1:0]  col_q;
   logic            col_wrap;
   logic            row_wrap;
   logic            load_done;
   logic            o_take;

   assign in_take   = (phase == PH_LOAD) && a_valid && b_valid;
   assign o_valid   = (phase == PH_EMIT);
   assign col_wrap  = (col_q == RCW'(DIM - 1));
   assign row_wrap  = (row_q == RCW'(DIM - 1));
   assign o_last    = o_valid && col_wrap && row_wrap;
   assign load_done = in_take && (ld_q == IDXW'(CELLS - 1));
   assign o_take    = o_valid && o_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_LOAD;
         ld_q  <= '0;
         row_q <= '0;
         col_q <= '0;
      end else begin
         if (in_take) begin
            ld_q <= load_done ? '0 : ld_q + 1'b1;
         end
         if (o_take) begin
            col_q <= col_wrap ? '0 : col_q + 1'b1;
            if (col_wrap) begin
               row_q <= row_wrap ? '0 : row_q + 1'b1;
            end
         end
         if (load_done) begin
            phase <= PH_EMIT;
         end else if (o_take && o_last) begin
            phase <= PH_LOAD;
         end
      end
   end

   assign ld_idx  = ld_q;
   assign row_sel = row_q;
   assign col_sel = col_q;

endmodule

// File: rtl/mxm_stream_mul.sv
// Streaming square matrix multiplier: two lockstep operand streams in,
// one result packet of DIM*DIM beats out, one dot product per cycle.
module mxm_stream_mul #(
   parameter int DIM = 4,
   parameter int DW = 32,
   parameter bit ADD_TREE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [DW-1:0]   a_tdata,
   input  logic            a_tvalid,
   output logic            a_tready,
   input  logic [DW-1:0]   b_tdata,
   input  logic            b_tvalid,
   output logic            b_tready,
   output logic [DW-1:0]   m_tdata,
   output logic            m_tvalid,
   input  logic            m_tready,
   output logic [DW/8-1:0] m_tkeep,
   output logic            m_tlast
);

   localparam int CELLS = DIM * DIM;
   localparam int IDXW  = $clog2(CELLS);
   localparam int RCW   = $clog2(DIM);

   if (DIM < 2) begin : g_bad_dim
      $error("mxm_stream_mul: DIM must be at least 2");
   end
   if ((DW < 8) || ((DW % 8) != 0)) begin : g_bad_dw
      $error("mxm_stream_mul: DW must be a positive multiple of 8");
   end

   logic                    take;
   logic [IDXW-1:0]         ld_idx;
   logic [RCW-1:0]          row_sel;
   logic [RCW-1:0]          col_sel;
   logic [CELLS-1:0][DW-1:0] a_cells;
   logic [CELLS-1:0][DW-1:0] b_cells;
   logic [DIM-1:0][DW-1:0]  row_v;
   logic [DIM-1:0][DW-1:0]  col_v;

   mxm_sequencer #(.DIM(DIM)) i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .a_valid (a_tvalid),
      .b_valid (b_tvalid),
      .o_ready (m_tready),
      .in_take (take),
      .o_valid (m_tvalid),
      .o_last  (m_tlast),
      .ld_idx  (ld_idx),
      .row_sel (row_sel),
      .col_sel (col_sel)
   );

   mxm_operand_bank #(.DIM(DIM), .DW(DW)) i_bank_a (
      .clk     (clk),
      .wr_en   (take),
      .wr_idx  (ld_idx),
      .wr_data (a_tdata),
      .cells   (a_cells)
   );

   mxm_operand_bank #(.DIM(DIM), .DW(DW)) i_bank_b (
      .clk     (clk),
      .wr_en   (take),
      .wr_idx  (ld_idx),
      .wr_data (b_tdata),
      .cells   (b_cells)
   );

   // Row of A and column of B addressed by the result position
   always_comb begin
      for (int k = 0; k < DIM; k++) begin
         row_v[k] = a_cells[int'(row_sel) * DIM + k];
         col_v[k] = b_cells[k * DIM + int'(col_sel)];
      end
   end

   mxm_dot_unit #(.DIM(DIM), .DW(DW), .ADD_TREE(ADD_TREE)) i_dot (
      .row_v (row_v),
      .col_v (col_v),
      .dot   (m_tdata)
   );

   assign a_tready = take;
   assign b_tready = take;
   assign m_tkeep  = '1;

endmodule

// File: rtl/mxm_stream_mul_chk.sv
// Port-level protocol checker, attached to every instance of the top.
module mxm_stream_mul_chk #(
   parameter int DIM = 4,
   parameter int DW = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            a_tvalid,
   input logic            a_tready,
   input logic            b_tvalid,
   input logic            b_tready,
   input logic [DW-1:0]   m_tdata,
   input logic            m_tvalid,
   input logic            m_tready,
   input logic [DW/8-1:0] m_tkeep,
   input logic            m_tlast
);

   localparam int CELLS = DIM * DIM;
   localparam int CNTW  = $clog2(CELLS + 1);

   logic [CNTW-1:0] in_cnt;
   logic [CNTW-1:0] out_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_cnt  <= '0;
         out_cnt <= '0;
      end else begin
         if (a_tvalid && a_tready) begin
            in_cnt <= in_cnt + 1'b1;
         end
         if (m_tvalid && m_tready) begin
            if (m_tlast) begin
               in_cnt  <= '0;
               out_cnt <= '0;
            end else begin
               out_cnt <= out_cnt + 1'b1;
            end
         end
      end
   end

   AST_READY_PAIRED: assert property (@(posedge clk) disable iff (!rst_n) a_tready == b_tready); // R1
   AST_READY_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n) a_tready |-> (a_tvalid && b_tvalid)); // R1
   AST_NO_LOAD_IN_EMIT: assert property (@(posedge clk) disable iff (!rst_n) m_tvalid |-> !a_tready); // R1
   AST_LOAD_BEFORE_OUT: assert property (@(posedge clk) disable iff (!rst_n) m_tvalid |-> (in_cnt == CNTW'(CELLS))); // R3
   AST_LAST_ON_FINAL: assert property (@(posedge clk) disable iff (!rst_n) m_tvalid |-> (m_tlast == (out_cnt == CNTW'(CELLS - 1)))); // R6
   AST_KEEP_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n) m_tvalid |-> (&m_tkeep)); // R7
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast))); // R8
   AST_BACK_TO_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (m_tvalid && m_tready && m_tlast) |=> !m_tvalid); // R9
   AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n) (m_tvalid && m_tready && !m_tlast) |=> m_tvalid); // R10
   AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !m_tvalid); // R11

endmodule

bind mxm_stream_mul mxm_stream_mul_chk #(.DIM(DIM), .DW(DW)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .a_tvalid (a_tvalid),
   .a_tready (a_tready),
   .b_tvalid (b_tvalid),
   .b_tready (b_tready),
   .m_tdata  (m_tdata),
   .m_tvalid (m_tvalid),
   .m_tready (m_tready),
   .m_tkeep  (m_tkeep),
   .m_tlast  (m_tlast)
);

// File: tb/test_mxm_stream_mul.sv
module test_mxm_stream_mul;

   localparam int DIM   = 4;
   localparam int DW    = 32;
   localparam int CELLS = DIM * DIM;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] a_tdata = '0;
   logic          a_tvalid = 1'b0;
   logic          a_tready;
   logic [DW-1:0] b_tdata = '0;
   logic          b_tvalid = 1'b0;
   logic          b_tready;
   logic [DW-1:0] m_tdata;
   logic          m_tvalid;
   logic          m_tready = 1'b0;
   logic [3:0]    m_tkeep;
   logic          m_tlast;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   logic [31:0] mat_a [CELLS];
   logic [31:0] mat_b [CELLS];
   logic [31:0] mat_c [CELLS];

   always #5 clk = ~clk;

   mxm_stream_mul i_mxm_stream_mul (
      .clk      (clk),
      .rst_n    (rst_n),
      .a_tdata  (a_tdata),
      .a_tvalid (a_tvalid),
      .a_tready (a_tready),
      .b_tdata  (b_tdata),
      .b_tvalid (b_tvalid),
      .b_tready (b_tready),
      .m_tdata  (m_tdata),
      .m_tvalid (m_tvalid),
      .m_tready (m_tready),
      .m_tkeep  (m_tkeep),
      .m_tlast  (m_tlast)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic void summary();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
   endfunction

   // Reference product, row-major, modulo 2^32
   function automatic void compute_ref();
      for (int i = 0; i < DIM; i++) begin
         for (int j = 0; j < DIM; j++) begin
            logic [31:0] acc = '0;
            for (int k = 0; k < DIM; k++) begin
               acc = acc + mat_a[i*DIM+k] * mat_b[k*DIM+j];
            end
            mat_c[i*DIM+j] = acc;
         end
      end
   endfunction

   function automatic void fill(input int mode);
      for (int n = 0; n < CELLS; n++) begin
         case (mode)
            1: begin mat_a[n] = ((n / DIM) == (n % DIM)) ? 32'd1 : 32'd0; mat_b[n] = $urandom(); end
            2: begin mat_a[n] = 32'h7fff_ffff; mat_b[n] = 32'h7fff_ffff; end
            3: begin mat_a[n] = 32'h8000_0000; mat_b[n] = 32'hffff_ffff; end
            4: begin mat_a[n] = 32'($signed($urandom_range(200)) - 100); mat_b[n] = 32'($signed($urandom_range(200)) - 100); end
            5: begin mat_a[n] = 32'(n); mat_b[n] = 32'(n); end
            default: begin mat_a[n] = $urandom(); mat_b[n] = $urandom(); end
         endcase
      end
      compute_ref();
   endfunction

   // One product: stall and gap are percentages; abort_ld/abort_ob stop
   // the run at that load count or output count and apply reset.
   task automatic run_case(input int stall, input int gap, input int abort_ld, input int abort_ob);
      int  ld = 0;
      int  ob = 0;
      int  cyc = 0;
      bit  prev_stall = 1'b0;
      logic [31:0] prev_d = '0;
      logic        prev_l = 1'b0;
      bit  aborted = 1'b0;
      while (ob < CELLS && cyc < 3000) begin
         if (ld == abort_ld || ob == abort_ob) begin
            aborted = 1'b1;
            break;
         end
         @(negedge clk);
         cyc++;
         a_tvalid = (int'($urandom_range(99)) >= gap);
         b_tvalid = (int'($urandom_range(99)) >= gap);
         a_tdata  = (ld < CELLS && a_tvalid) ? mat_a[ld] : $urandom();
         b_tdata  = (ld < CELLS && b_tvalid) ? mat_b[ld] : $urandom();
         m_tready = (int'($urandom_range(99)) >= stall);
         #1;
         begin
            logic exp_rdy = (ld < CELLS) && a_tvalid && b_tvalid;
            check((ld == 0 && cyc == 1) ? "R9 reload ready" : "R1 a_tready", 32'(a_tready), 32'(exp_rdy));
            check("R1 b_tready", 32'(b_tready), 32'(exp_rdy));
         end
         if (prev_stall) begin
            check("R8 held data", m_tdata, prev_d);
            check("R8 held last", 32'(m_tlast), 32'(prev_l));
         end
         if (ld < CELLS) begin
            check("R3 no result before load", 32'(m_tvalid), 32'd0);
         end else begin
            check("R10 result offered", 32'(m_tvalid), 32'd1);
            check("R7 keep", 32'(m_tkeep), 32'hf);
            if (m_tvalid && m_tready) begin
               check("R2 R4 R5 result", m_tdata, mat_c[ob]);
               check("R6 last", 32'(m_tlast), 32'(ob == CELLS - 1));
               ob++;
            end
         end
         prev_stall = m_tvalid && !m_tready;
         prev_d     = m_tdata;
         prev_l     = m_tlast;
         if (a_tready && a_tvalid && b_tvalid) ld++;
      end
      if (aborted) begin
         @(negedge clk);
         rst_n    = 1'b0;
         a_tvalid = 1'b0;
         b_tvalid = 1'b0;
         @(negedge clk);
         check("R11 reset clears valid", 32'(m_tvalid), 32'd0);
         rst_n = 1'b1;
      end else begin
         check("R9 full packet", 32'(ob), 32'(CELLS));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7741));
      repeat (3) @(negedge clk);
      check("R11 reset valid", 32'(m_tvalid), 32'd0);
      check("R1 idle ready", 32'(a_tready), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 post reset valid", 32'(m_tvalid), 32'd0);

      // Directed corners at full throughput
      for (int mode = 1; mode <= 5; mode++) begin
         fill(mode);
         run_case(0, 0, 99, 99);
      end
      // Reset during loading and during emission
      fill(0);
      run_case(0, 0, 5, 99);
      fill(5);
      run_case(0, 0, 99, 99);
      fill(0);
      run_case(20, 0, 99, 3);
      fill(4);
      run_case(0, 0, 99, 99);
      // Random stimulus with gaps and stalls
      for (int t = 0; t < 30; t++) begin
         fill((t % 3 == 0) ? 4 : 0);
         run_case(int'($urandom_range(60)), int'($urandom_range(50)), 99, 99);
      end
      finished = 1'b1;
      summary();
      $finish;
   end

endmodule